// File: doc/BRIEF.md
# Clock Fan-out Gate with Runt-Free Output Enables

This block takes one core clock and sends it to a set of differential output pairs and to one feedback pair. A per-pair enable word decides which pairs drive. The word comes in asynchronously from the control registers, so the block retimes it into the core clock domain.

Each enable is captured only on a falling edge of the core clock. A gated output therefore starts or stops only at the start of a low phase, and every high pulse it emits lasts a full half-period.

A disabled pair holds both of its signals low and drops its drive-enable, so the external pad drivers put the pair into high impedance. The feedback pair ignores the enable word.

A test-bypass input picks the core clock source: the raw reference clock or the PLL clock. The PLL clock enters as an ordinary input. The select change is handed across with two interlocked select paths, one timed in each source domain, so neither source is cut off mid-pulse.

Top module: `clk_fanout_gate`

## Requirements
- R1: The enable word has one bit per output pair. Bit i controls pair i, and 1 enables the pair. The default build has ten pairs.
- R2: While a pair is disabled, its drive-enable output is 0 and both its true and complement signals are held at 0, so the pad drivers place the pair in high impedance.
- R3: While a pair is enabled, its drive-enable is 1, its true signal follows the core clock, and its complement is the inverse of its true signal.
- R4: The feedback pair always toggles with the core clock, with its complement inverted, whatever the enable word holds.
- R5: Every high pulse on a pair's true output lasts exactly one half-period of the selected source clock. No shortened pulse appears when enables change.
- R6: A new enable word reaches the drive-enables on the falling core-clock edge that follows the second rising core-clock edge after the change. It does not reach them on the falling edge after the first rising edge.
- R7: With bypass at 1 the core clock is the reference clock. With bypass at 0 it is the PLL clock.
- R8: Switching the source never produces a high phase on the feedback output shorter than a full source half-period, nor a low phase shorter than the shorter source half-period. The two source selects are never active together.
- R9: While reset is asserted, all pairs are enabled and the PLL clock is the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Raw reference clock |
| pllClk | input | 1 | PLL output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bypassSel | input | 1 | 1 selects the reference clock as source, 0 selects the PLL clock |
| enableMask | input | NUM_PAIRS | Per-pair enable, asynchronous to the clocks |
| pairTrue | output | NUM_PAIRS | True clock signal of each pair |
| pairComp | output | NUM_PAIRS | Complement clock signal of each pair |
| pairOe | output | NUM_PAIRS | Pad drive-enable of each pair, 0 means high impedance |
| fbTrue | output | 1 | Feedback clock, true signal |
| fbComp | output | 1 | Feedback clock, complement signal |

## Verification
The assertions assume that both source clocks run freely, and that reset is held long enough for the source select flops to settle. The stimulus meets this by starting both clocks at time zero and keeping them running without interruption. Enable words and the bypass input are changed at arbitrary times, which fits their asynchronous nature. After each change the stimulus waits several feedback cycles before it samples the outputs. Pulse-width monitors run throughout, so every pulse emitted during an enable or source transition is measured rather than only the settled state.

// File: rtl/clk_fanout_gate_pkg.sv
`timescale 1ns/1ps
package clk_fanout_gate_pkg;

  // Strobes from control to datapath: which source feeds the core clock.
  typedef struct packed {
    logic refEn;
    logic pllEn;
  } srcSel_t;

endpackage

// File: rtl/clk_fanout_gate_ctrl.sv
`timescale 1ns/1ps
module clk_fanout_gate_ctrl
  import clk_fanout_gate_pkg::*;
#(
  parameter int NUM_PAIRS = 10,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_PAIRS-1:0] RESET_MASK = '1
) (
  input  logic                 refClk,
  input  logic                 pllClk,
  input  logic                 coreClk,
  input  logic                 rstN,
  input  logic                 bypassSel,
  input  logic [NUM_PAIRS-1:0] enableMask,
  output srcSel_t              sel,
  output logic [NUM_PAIRS-1:0] gateEn
);

  localparam int LAST = SYNC_STAGES - 1;

  // Source select handoff: each side waits until the other side is off.
  logic refMeta, refEn, pllMeta, pllEn;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) refMeta <= 1'b0;
    else       refMeta <= bypassSel & ~pllEn;
  end

  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) refEn <= 1'b0;
    else       refEn <= refMeta;
  end

  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) pllMeta <= 1'b1;
    else       pllMeta <= ~bypassSel & ~refEn;
  end

  always_ff @(negedge pllClk or negedge rstN) begin
    if (!rstN) pllEn <= 1'b1;
    else       pllEn <= pllMeta;
  end

  assign sel.refEn = refEn;
  assign sel.pllEn = pllEn;

  // Enable synchronizer in the core clock domain.
  logic [NUM_PAIRS-1:0] syncChain [SYNC_STAGES];

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) syncChain[0] <= RESET_MASK;
    else       syncChain[0] <= enableMask;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge coreClk or negedge rstN) begin
        if (!rstN) syncChain[s] <= RESET_MASK;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  // Falling-edge capture, so enables only move while the clock is low.
  always_ff @(negedge coreClk or negedge rstN) begin
    if (!rstN) gateEn <= RESET_MASK;
    else       gateEn <= syncChain[LAST];
  end

  AST_SRC_EXCLUSIVE: assert property (@(posedge refClk) disable iff (!rstN)
    !(refEn && pllEn)) else $error("both sources selected"); // R8

endmodule

// File: rtl/clk_fanout_gate_dp.sv
`timescale 1ns/1ps
module clk_fanout_gate_dp
  import clk_fanout_gate_pkg::*;
#(
  parameter int NUM_PAIRS = 10
) (
  input  logic                 refClk,
  input  logic                 pllClk,
  input  logic                 rstN,
  input  srcSel_t              sel,
  input  logic [NUM_PAIRS-1:0] gateEn,
  output logic                 coreClk,
  output logic [NUM_PAIRS-1:0] pairTrue,
  output logic [NUM_PAIRS-1:0] pairComp,
  output logic [NUM_PAIRS-1:0] pairOe,
  output logic                 fbTrue,
  output logic                 fbComp
);

  assign coreClk = (refClk & sel.refEn) | (pllClk & sel.pllEn);

  assign fbTrue = coreClk;
  assign fbComp = ~coreClk;

  generate
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      assign pairTrue[i] = coreClk & gateEn[i];
      assign pairComp[i] = ~coreClk & gateEn[i];
      assign pairOe[i]   = gateEn[i];

      AST_OFF_QUIET: assert property (@(posedge refClk) disable iff (!rstN)
        !pairOe[i] |-> (!pairTrue[i] && !pairComp[i])) else $error("disabled pair drives"); // R2
      AST_PAIR_INVERSE: assert property (@(posedge refClk) disable iff (!rstN)
        pairOe[i] |-> (pairComp[i] != pairTrue[i])) else $error("pair not complementary"); // R3
      AST_PAIR_TRACKS_FB: assert property (@(posedge refClk) disable iff (!rstN)
        pairOe[i] |-> (pairTrue[i] == fbTrue)) else $error("pair off feedback phase"); // R3
    end
  endgenerate

  AST_FB_INVERSE: assert property (@(posedge refClk) disable iff (!rstN)
    fbComp != fbTrue) else $error("feedback pair not complementary"); // R4

endmodule

// File: rtl/clk_fanout_gate.sv
`timescale 1ns/1ps
module clk_fanout_gate
  import clk_fanout_gate_pkg::*;
#(
  parameter int NUM_PAIRS = 10,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_PAIRS-1:0] RESET_MASK = '1
) (
  input  logic                 refClk,
  input  logic                 pllClk,
  input  logic                 rstN,
  input  logic                 bypassSel,
  input  logic [NUM_PAIRS-1:0] enableMask,
  output logic [NUM_PAIRS-1:0] pairTrue,
  output logic [NUM_PAIRS-1:0] pairComp,
  output logic [NUM_PAIRS-1:0] pairOe,
  output logic                 fbTrue,
  output logic                 fbComp
);

  srcSel_t              sel;
  logic [NUM_PAIRS-1:0] gateEn;
  logic                 coreClk;

  clk_fanout_gate_ctrl #(
    .NUM_PAIRS(NUM_PAIRS),
    .SYNC_STAGES(SYNC_STAGES),
    .RESET_MASK(RESET_MASK)
  ) u_ctrl (
    .refClk(refClk),
    .pllClk(pllClk),
    .coreClk(coreClk),
    .rstN(rstN),
    .bypassSel(bypassSel),
    .enableMask(enableMask),
    .sel(sel),
    .gateEn(gateEn)
  );

  clk_fanout_gate_dp #(
    .NUM_PAIRS(NUM_PAIRS)
  ) u_dp (
    .refClk(refClk),
    .pllClk(pllClk),
    .rstN(rstN),
    .sel(sel),
    .gateEn(gateEn),
    .coreClk(coreClk),
    .pairTrue(pairTrue),
    .pairComp(pairComp),
    .pairOe(pairOe),
    .fbTrue(fbTrue),
    .fbComp(fbComp)
  );

endmodule

// File: tb/sim_clk_fanout_gate.sv
`timescale 1ns/1ps
module sim_clk_fanout_gate;

  localparam int CLK_PERIOD = 10;
  localparam int PLL_PERIOD = 6;
  localparam int NP = 10;
  localparam int REF_HALF = CLK_PERIOD / 2;
  localparam int PLL_HALF = PLL_PERIOD / 2;

  logic refClk = 1'b0;
  logic pllClk = 1'b0;
  logic rstN = 1'b0;
  logic bypassSel = 1'b0;
  logic [NP-1:0] enableMask = '1;
  logic [NP-1:0] pairTrue, pairComp, pairOe;
  logic fbTrue, fbComp;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(REF_HALF) refClk = ~refClk;
  always #(PLL_HALF) pllClk = ~pllClk;

  clk_fanout_gate #(.NUM_PAIRS(NP)) u0 (
    .refClk(refClk), .pllClk(pllClk), .rstN(rstN), .bypassSel(bypassSel),
    .enableMask(enableMask), .pairTrue(pairTrue), .pairComp(pairComp),
    .pairOe(pairOe), .fbTrue(fbTrue), .fbComp(fbComp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit isHalf(input longint w);
    return (w == REF_HALF) || (w == PLL_HALF);
  endfunction

  function automatic int expPeriod(input bit byp);
    return byp ? CLK_PERIOD : PLL_PERIOD;
  endfunction

  // R5: width of every high pulse on each pair true output.
  time riseT [NP];
  bit  seenRise [NP];
  generate
    for (genvar gi = 0; gi < NP; gi++) begin : g_mon
      always @(posedge pairTrue[gi]) begin
        riseT[gi] = $time;
        seenRise[gi] = rstN;
      end
      always @(negedge pairTrue[gi]) begin
        if (rstN && seenRise[gi]) begin
          check(isHalf($time - riseT[gi]), "R5", $sformatf("pair%0d high width", gi),
                $time - riseT[gi], REF_HALF);
        end
      end
    end
  endgenerate

  // R8: feedback phase widths across source switching.
  time fbRise = 0, fbFall = 0;
  bit  fbSeenRise = 0, fbSeenFall = 0;
  always @(posedge fbTrue) begin
    if (rstN && fbSeenFall)
      check(($time - fbFall) >= PLL_HALF, "R8", "feedback low width", $time - fbFall, PLL_HALF);
    fbRise = $time;
    fbSeenRise = rstN;
  end
  always @(negedge fbTrue) begin
    if (rstN && fbSeenRise)
      check(isHalf($time - fbRise), "R8", "feedback high width", $time - fbRise, REF_HALF);
    fbFall = $time;
    fbSeenFall = rstN;
  end

  task automatic waitFb(input int n);
    for (int k = 0; k < n; k++) @(posedge fbTrue);
  endtask

  task automatic checkPeriod(input string req, input bit byp);
    time t0;
    @(posedge fbTrue);
    t0 = $time;
    @(posedge fbTrue);
    check(($time - t0) == expPeriod(byp), req, "core period", $time - t0, expPeriod(byp));
  endtask

  task automatic checkPairs(input logic [NP-1:0] m);
    @(posedge fbTrue);
    #1;
    check(pairOe == m, "R1", "drive-enables", pairOe, m);
    check(pairTrue == m, "R3", "true in high phase", pairTrue, m);
    check(pairComp == '0, "R2", "complement in high phase", pairComp, 0);
    check(fbComp == 1'b0, "R4", "feedback complement high phase", fbComp, 0);
    @(negedge fbTrue);
    #1;
    check(pairTrue == '0, "R2", "true in low phase", pairTrue, 0);
    check(pairComp == m, "R3", "complement in low phase", pairComp, m);
    check(fbComp == 1'b1, "R4", "feedback complement low phase", fbComp, 1);
  endtask

  task automatic apply(input logic [NP-1:0] m, input bit byp);
    enableMask = m;
    bypassSel = byp;
    waitFb(8);
    checkPairs(m);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] m;
    bit byp;
    void'($urandom(32'd4242));
    enableMask = 10'h155;   // changed during reset: must be ignored
    #23;
    check(pairOe == '1, "R9", "drive-enables in reset", pairOe, 10'h3FF);
    checkPeriod("R9", 1'b0);
    #2;
    rstN = 1'b1;
    enableMask = '1;
    waitFb(4);
    checkPairs('1);

    // R6: exact enable latency.
    @(posedge fbTrue); #1;
    enableMask = 10'h3FE;
    @(posedge fbTrue); @(negedge fbTrue); #1;
    check(pairOe == 10'h3FF, "R6", "old enables after first fall", pairOe, 10'h3FF);
    @(posedge fbTrue); @(negedge fbTrue); #1;
    check(pairOe == 10'h3FE, "R6", "new enables after second fall", pairOe, 10'h3FE);

    // Directed corner cases.
    apply(10'h001, 1'b0);
    apply(10'h200, 1'b0);
    apply('0, 1'b0);
    checkPeriod("R4", 1'b0);
    apply('0, 1'b1);
    checkPeriod("R7", 1'b1);
    apply(10'h2AA, 1'b1);
    checkPeriod("R7", 1'b1);
    apply(10'h155, 1'b0);
    checkPeriod("R7", 1'b0);

    // Random enable words and occasional source switches.
    byp = 1'b0;
    for (int it = 0; it < 30; it++) begin
      m = NP'($urandom);
      if (($urandom % 4) == 0) byp = ~byp;
      #($urandom % 7);
      apply(m, byp);
      checkPeriod("R7", byp);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule